// File: doc/BRIEF.md
# Second-Order Recursive Audio Filter Section

This block filters a stream of 48-bit signed audio samples with one second-order recursive section in direct form I. Samples use a 25.23 fixed-point layout, meaning 25 integer bits and 23 fractional bits. The five 28-bit coefficients use a 5.23 layout. Each new sample arrives with a one-cycle strobe. The filtered sample appears with its own one-cycle strobe on the next cycle.

The section keeps its own history of the two previous inputs and the two previous outputs. Every product is formed at full width. The five products are summed without any rounding. The sum is realigned to 25.23 by an arithmetic shift, then clamped to the 48-bit range.

Coefficients are loaded through a simple write port, one 32-bit word per coefficient. After reset the coefficient set passes the signal through unchanged. A write takes effect from the sample after the one in flight, never partway through a computation.

Top module: `iir2_df1_engine`

## Requirements
- R1: While the internal reset is asserted, and until the first sample is accepted after reset, `out_valid` is 0 and `out_sample` is 0. The internal reset follows `rst_n` low at once and is released two clock edges after `rst_n` rises.
- R2: After reset the coefficients are b0 = 1.0 (raw 0x0800000) and b1 = b2 = a1 = a2 = 0, so each output equals its input. A later reset restores this set and clears the history.
- R3: A sample accepted at a clock edge with `in_valid` = 1 gives `out_valid` = 1 for exactly the following cycle. `out_sample` keeps its value while no sample is accepted.
- R4: The output is y = b0·x[n] + b1·x[n-1] + b2·x[n-2] + a1·y[n-1] + a2·y[n-2], where the feedback coefficients are added with the sign they are stored with. The sum is exact, with products of 48 × 28 bits, and is then shifted right by 23 bits, rounding toward minus infinity.
- R5: A shifted sum above the 48-bit positive limit gives 0x7FFF_FFFF_FFFF.
- R6: A shifted sum below the 48-bit negative limit gives 0x8000_0000_0000.
- R7: A write with `coef_we` = 1 stores bits 27:0 of `coef_wdata` into the coefficient picked by `coef_sel`: 0 = b0, 1 = b1, 2 = b2, 3 = a1, 4 = a2. Bits 31:28 of the word are ignored, and `coef_sel` values 5 to 7 change nothing.
- R8: A coefficient write in the same cycle as an accepted sample does not affect that sample's output. It applies from the next sample on.
- R9: The history advances only on accepted samples. y[n-1] holds the clamped output, not the raw sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 3 | Coefficient index (0 b0, 1 b1, 2 b2, 3 a1, 4 a2) |
| coef_wdata | input | 32 | Coefficient word; bits 27:0 carry the 5.23 value |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 48 | Input sample, 25.23 signed |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 48 | Filtered sample, 25.23 signed, clamped |

## Verification
The filtered sample and its strobe are registered once, so they are due exactly one clock edge after the edge that accepts the input. The bench drives inputs on the falling edge and samples on the next falling edge, which is after that single register. It then checks one further falling edge to confirm that the strobe has dropped and the value is held. Coefficient writes are likewise registered once, so a write and a sample presented on the same edge let the bench confirm that the old set was used. Internal reset release takes two edges, and the bench waits several cycles before its first stimulus.

// File: rtl/iir2_pkg.sv
package iir2_pkg;
  localparam int unsigned NUM_TAPS = 5;
  localparam int unsigned SEL_W    = 3;
  typedef enum logic [SEL_W-1:0] {
    TAP_B0 = 3'd0,
    TAP_B1 = 3'd1,
    TAP_B2 = 3'd2,
    TAP_A1 = 3'd3,
    TAP_A2 = 3'd4
  } tap_e;
endpackage

// File: rtl/iir2_coef_bank.sv
module iir2_coef_bank #(
  parameter int unsigned COEF_W = 28,
  parameter int unsigned FRAC_W = 23,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NTAP   = iir2_pkg::NUM_TAPS
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [iir2_pkg::SEL_W-1:0]      sel,
  input  logic [WORD_W-1:0]               wdata,
  output logic [NTAP-1:0][COEF_W-1:0]     coef
);
  localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << FRAC_W;

  logic [NTAP-1:0]             wr_en;
  logic [NTAP-1:0][COEF_W-1:0] coef_q;
  logic [NTAP-1:0][COEF_W-1:0] coef_d;
  logic                        unused_hi_bits;

  assign unused_hi_bits = ^wdata[WORD_W-1:COEF_W];

  for (genvar gi = 0; gi < NTAP; gi++) begin : g_tap
    localparam logic [COEF_W-1:0] RST_VAL = (gi == 0) ? UNITY : '0;

    always_comb begin
      wr_en[gi]  = we && (sel == iir2_pkg::SEL_W'(gi));
      coef_d[gi] = wr_en[gi] ? wdata[COEF_W-1:0] : coef_q[gi];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) coef_q[gi] <= RST_VAL;
      else if (wr_en[gi]) coef_q[gi] <= coef_d[gi];
    end
  end

  assign coef = coef_q;

  // R8: coefficients only move on a write strobe
  p_coef_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(coef_q));
  // R7: at most one tap is written per cycle
  p_one_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));
endmodule

// File: rtl/iir2_delay_line.sv
module iir2_delay_line #(
  parameter int unsigned DATA_W = 48
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic signed [DATA_W-1:0] x_in,
  input  logic signed [DATA_W-1:0] y_in,
  output logic signed [DATA_W-1:0] x1,
  output logic signed [DATA_W-1:0] x2,
  output logic signed [DATA_W-1:0] y1,
  output logic signed [DATA_W-1:0] y2
);
  logic signed [DATA_W-1:0] x1_d, x2_d, y1_d, y2_d;

  always_comb begin
    x1_d = x1;
    x2_d = x2;
    y1_d = y1;
    y2_d = y2;
    if (adv) begin
      x1_d = x_in;
      x2_d = x1;
      y1_d = y_in;
      y2_d = y1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1 <= '0;
      x2 <= '0;
      y1 <= '0;
      y2 <= '0;
    end else if (adv) begin
      x1 <= x1_d;
      x2 <= x2_d;
      y1 <= y1_d;
      y2 <= y2_d;
    end
  end

  // R9: history is frozen between samples
  p_hist_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(x1) && $stable(x2) && $stable(y1) && $stable(y2)));
  // R9: x history follows the accepted input
  p_x_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (x1 == $past(x_in) && x2 == $past(x1)));
endmodule

// File: rtl/iir2_mac.sv
module iir2_mac #(
  parameter int unsigned DATA_W = 48,
  parameter int unsigned COEF_W = 28,
  parameter int unsigned FRAC_W = 23,
  parameter int unsigned GUARD  = 3,
  parameter int unsigned NTAP   = iir2_pkg::NUM_TAPS
) (
  input  logic [NTAP-1:0][DATA_W-1:0] samp,
  input  logic [NTAP-1:0][COEF_W-1:0] coef,
  output logic signed [DATA_W-1:0]    y_sat
);
  localparam int unsigned PROD_W = DATA_W + COEF_W;
  localparam int unsigned ACC_W  = PROD_W + GUARD;
  localparam int unsigned TOP_W  = ACC_W - FRAC_W - DATA_W + 1;
  localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [NTAP-1:0][PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]            acc;
  logic [TOP_W-1:0]                   top_bits;

  for (genvar gi = 0; gi < NTAP; gi++) begin : g_mul
    logic signed [PROD_W-1:0] sx, sc;
    assign sx = {{COEF_W{samp[gi][DATA_W-1]}}, samp[gi]};
    assign sc = {{DATA_W{coef[gi][COEF_W-1]}}, coef[gi]};
    assign prod[gi] = sx * sc;
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < int'(NTAP); i++) begin
      acc = acc + {{GUARD{prod[i][PROD_W-1]}}, prod[i]};
    end
    top_bits = acc[ACC_W-1:FRAC_W+DATA_W-1];
    if (top_bits == '0 || top_bits == '1) y_sat = acc[FRAC_W+DATA_W-1:FRAC_W];
    else if (acc[ACC_W-1])                y_sat = NEG_LIM;
    else                                  y_sat = POS_LIM;
  end
endmodule

// File: rtl/iir2_df1_engine.sv
module iir2_df1_engine #(
  parameter int unsigned DATA_W = 48,
  parameter int unsigned COEF_W = 28,
  parameter int unsigned FRAC_W = 23,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned GUARD  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       coef_we,
  input  logic [iir2_pkg::SEL_W-1:0] coef_sel,
  input  logic [WORD_W-1:0]          coef_wdata,
  input  logic                       in_valid,
  input  logic [DATA_W-1:0]          in_sample,
  output logic                       out_valid,
  output logic [DATA_W-1:0]          out_sample
);
  localparam int unsigned NTAP = iir2_pkg::NUM_TAPS;

  logic [1:0]                  rst_pipe;
  logic                        rst_sync_n;
  logic [NTAP-1:0][COEF_W-1:0] coef;
  logic [NTAP-1:0][DATA_W-1:0] samp;
  logic signed [DATA_W-1:0]    x1, x2, y1, y2, y_sat;
  logic                        out_valid_d;
  logic [DATA_W-1:0]           out_sample_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  iir2_coef_bank #(.COEF_W(COEF_W), .FRAC_W(FRAC_W), .WORD_W(WORD_W), .NTAP(NTAP)) u_coef (
    .clk(clk), .rst_n(rst_sync_n), .we(coef_we), .sel(coef_sel),
    .wdata(coef_wdata), .coef(coef)
  );

  iir2_delay_line #(.DATA_W(DATA_W)) u_hist (
    .clk(clk), .rst_n(rst_sync_n), .adv(in_valid), .x_in(in_sample),
    .y_in(y_sat), .x1(x1), .x2(x2), .y1(y1), .y2(y2)
  );

  always_comb begin
    samp[iir2_pkg::TAP_B0] = in_sample;
    samp[iir2_pkg::TAP_B1] = x1;
    samp[iir2_pkg::TAP_B2] = x2;
    samp[iir2_pkg::TAP_A1] = y1;
    samp[iir2_pkg::TAP_A2] = y2;
  end

  iir2_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .GUARD(GUARD), .NTAP(NTAP)) u_mac (
    .samp(samp), .coef(coef), .y_sat(y_sat)
  );

  always_comb begin
    out_valid_d  = in_valid;
    out_sample_d = in_valid ? y_sat : out_sample;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= out_valid_d;
      if (in_valid) out_sample <= out_sample_d;
    end
  end

  // R3: one output strobe per accepted sample, one cycle later
  p_strobe_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);
  p_no_extra_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(out_sample));
  // R9: newest output history equals the presented output
  p_feedback_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (y1 == out_sample));
endmodule

// File: tb/iir2_df1_engine_bench.sv
module iir2_df1_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        coef_we = 1'b0;
  logic [2:0]  coef_sel = '0;
  logic [31:0] coef_wdata = '0;
  logic        in_valid = 1'b0;
  logic [47:0] in_sample = '0;
  logic        out_valid;
  logic [47:0] out_sample;

  int checks = 0;
  int fails  = 0;

  logic signed [27:0] mc [5];
  logic signed [47:0] mx1, mx2, my1, my2;

  localparam logic signed [79:0] MAXV = 80'sd140737488355327;
  localparam logic signed [79:0] MINV = -80'sd140737488355328;

  always #10 clk = ~clk;

  iir2_df1_engine u_iir2_df1_engine (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_sel(coef_sel),
    .coef_wdata(coef_wdata), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic signed [79:0] mul(input logic signed [47:0] x, input logic signed [27:0] c);
    logic signed [79:0] ex, ec;
    ex = x;
    ec = c;
    return ex * ec;
  endfunction

  function automatic logic signed [47:0] model_y(input logic signed [47:0] x);
    logic signed [79:0] acc, t;
    acc = mul(x, mc[0]) + mul(mx1, mc[1]) + mul(mx2, mc[2]) + mul(my1, mc[3]) + mul(my2, mc[4]);
    t = acc >>> 23;
    if (t > MAXV) return 48'h7FFF_FFFF_FFFF;
    if (t < MINV) return 48'h8000_0000_0000;
    return t[47:0];
  endfunction

  task automatic model_reset();
    mc[0] = 28'h0800000;
    for (int i = 1; i < 5; i++) mc[i] = '0;
    mx1 = '0; mx2 = '0; my1 = '0; my2 = '0;
  endtask

  task automatic model_push(input logic signed [47:0] x, input logic signed [47:0] y);
    mx2 = mx1; mx1 = x; my2 = my1; my1 = y;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0 && out_sample == '0, "R1 in reset", {15'd0, out_valid, out_sample}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0 && out_sample == '0, "R1 after release", {15'd0, out_valid, out_sample}, 64'd0);
    model_reset();
  endtask

  task automatic wcoef(input logic [2:0] sel, input logic [31:0] w);
    coef_we = 1'b1; coef_sel = sel; coef_wdata = w;
    @(negedge clk);
    coef_we = 1'b0;
    if (sel < 3'd5) mc[sel] = w[27:0];
  endtask

  // sends one sample, checks output one edge later and the hold after that
  task automatic send(input logic [47:0] x, input string rq, output logic [47:0] got);
    logic [47:0] exp;
    exp = model_y(x);
    in_sample = x; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    got = out_sample;
    chk(out_valid == 1'b1, {rq, " R3 strobe"}, {63'd0, out_valid}, 64'd1);
    chk(out_sample == exp, rq, {16'd0, out_sample}, {16'd0, exp});
    @(negedge clk);
    chk(out_valid == 1'b0 && out_sample == exp, "R3 hold", {15'd0, out_valid, out_sample}, {16'd0, exp});
    model_push(x, exp);
  endtask

  task automatic t_allpass();
    logic [47:0] g;
    send(48'h0000_1234_5678, "R2 allpass pos", g);
    send(48'hFFFF_8000_0001, "R2 allpass neg", g);
    send(48'h7FFF_FFFF_FFFF, "R2 allpass max", g);
    chk(g == 48'h7FFF_FFFF_FFFF, "R2 literal max", {16'd0, g}, 64'h7FFF_FFFF_FFFF);
  endtask

  task automatic t_filter();
    logic [47:0] g;
    wcoef(3'd0, 32'h0040_0000);
    wcoef(3'd1, 32'h0020_0000);
    wcoef(3'd2, 32'h0FF0_0000);
    wcoef(3'd3, 32'h0040_0000);
    wcoef(3'd4, 32'h0FE0_0000);
    send(48'h0000_0080_0000, "R4 impulse", g);
    send(48'h0000_0000_0000, "R4 tail1", g);
    send(48'h0000_0000_0000, "R4 tail2", g);
    send(48'hFFFF_FF00_0000, "R4 neg step", g);
    repeat (3) @(negedge clk);
    send(48'h0000_0123_4567, "R9 gap keeps history", g);
    wcoef(3'd1, 32'h0); wcoef(3'd2, 32'h0);
    wcoef(3'd3, 32'h0); wcoef(3'd4, 32'h0);
    wcoef(3'd0, 32'h0040_0000);
    send(48'hFFFF_FFFF_FFFF, "R4 floor", g);
    chk(g == 48'hFFFF_FFFF_FFFF, "R4 floor literal", {16'd0, g}, 64'h0000_FFFF_FFFF_FFFF);
  endtask

  task automatic t_saturate();
    logic [47:0] g;
    wcoef(3'd0, 32'h07FF_FFFF);
    send(48'h7FFF_FFFF_FFFF, "R5 positive clamp", g);
    chk(g == 48'h7FFF_FFFF_FFFF, "R5 literal", {16'd0, g}, 64'h7FFF_FFFF_FFFF);
    send(48'h8000_0000_0000, "R6 negative clamp", g);
    chk(g == 48'h8000_0000_0000, "R6 literal", {16'd0, g}, 64'h8000_0000_0000);
    wcoef(3'd3, 32'h0080_0000);
    send(48'h0000_0000_0000, "R9 clamped feedback", g);
    chk(g == 48'h8000_0000_0000, "R9 literal", {16'd0, g}, 64'h8000_0000_0000);
    wcoef(3'd3, 32'h0);
  endtask

  task automatic t_word_format();
    logic [47:0] g;
    wcoef(3'd0, 32'hA040_0000);
    send(48'h0000_0200_0000, "R7 upper bits ignored", g);
    chk(g == 48'h0000_0100_0000, "R7 literal half", {16'd0, g}, 64'h0000_0100_0000);
    wcoef(3'd5, 32'h0123_4567);
    wcoef(3'd7, 32'h0FFF_FFFF);
    send(48'h0000_0200_0000, "R7 sel5..7 no effect", g);
    wcoef(3'd0, 32'hF800_0000);
    send(48'h0000_0100_0000, "R7 sign from bit27", g);
  endtask

  task automatic t_write_during_sample();
    logic [47:0] exp;
    exp = model_y(48'h0000_0300_0000);
    coef_we = 1'b1; coef_sel = 3'd0; coef_wdata = 32'h0100_0000;
    in_sample = 48'h0000_0300_0000; in_valid = 1'b1;
    @(negedge clk);
    coef_we = 1'b0; in_valid = 1'b0;
    chk(out_valid && out_sample == exp, "R8 old set used", {16'd0, out_sample}, {16'd0, exp});
    model_push(48'h0000_0300_0000, exp);
    mc[0] = 28'h0100_0000;
    @(negedge clk);
    begin
      logic [47:0] g;
      send(48'h0000_0100_0000, "R8 new set next sample", g);
    end
  endtask

  task automatic t_rereset();
    logic [47:0] g;
    do_reset();
    send(48'h0000_0ABC_DEF0, "R2 defaults restored", g);
    chk(g == 48'h0000_0ABC_DEF0, "R2 literal", {16'd0, g}, 64'h0000_0ABC_DEF0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    t_allpass();
    t_filter();
    t_saturate();
    t_word_format();
    t_write_during_sample();
    t_rereset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule